// File: doc/BRIEF.md
# Dual-Clock Replay FIFO

This block is a first-in first-out buffer between two unrelated clock domains. A producer pushes words on the write clock and a consumer pops them on the read clock. Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy crosses to the other domain through a two-stage synchronizer. Each side then compares its own pointer with the synchronized copy of the far pointer to build its status flags.

The write domain registers two flags: full and almost-full. The read domain registers two flags: empty and almost-empty. The fill levels at which full, almost-full and almost-empty switch are inputs, so one netlist can serve several buffering policies. An active-low global reset clears both pointers and all flags.

A separate rewind input moves only the read pointer back to where it stood after the global reset. The words still held in storage are then read out a second time, in their original order. This replay is only meaningful while no write has overwritten the words being replayed.

Top module: `async_replay_fifo`

## Requirements
- R1: While and after the global reset `rstN` is low, `empty` and `almostEmpty` are 1, `full` and `almostFull` are 0, and `rdData` is 0.
- R2: Words are read out in the order they were accepted. `rdData` takes the next word at the read-clock edge on which a read is accepted.
- R3: `full` is registered on the write clock. It is 1 when the fill level seen by the write side is at least `fullLvl` (legal range 1 to 2^ADDR_W-1). It rises at the same edge that accepts the write reaching that level. A write while `full` is 1 is ignored, and `full` clears after enough reads become visible to the write side.
- R4: `almostFull` is registered on the write clock. It is 1 when the fill level seen by the write side is at least `afLvl` (legal range 1 to `fullLvl`-1).
- R5: `empty` is registered on the read clock. It is 1 when the fill level seen by the read side is 0. A read while `empty` is 1 is ignored and `rdData` holds its value.
- R6: `almostEmpty` is registered on the read clock. It is 1 when the fill level seen by the read side is at most `aeLvl` (legal range 1 to `fullLvl`-1).
- R7: A write is accepted only when both `wrCe` and `wrEn` are 1. A read is accepted only when both `rdCe` and `rdEn` are 1. With either enable low, the pointers and `rdData` do not change.
- R8: A 1 on `rdRewind` at a read-clock edge returns the read pointer to its post-reset position and leaves `rdData` unchanged. Later reads replay the stored words from the first one written, in order, and both sides' flags reflect the restored fill level. If rewind and a read coincide, rewind wins and the read is ignored.
- R9: Each Gray pointer changes by at most one bit per clock edge, except for the read pointer on a rewind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| rstN | input | 1 | Global reset, active low, asynchronous assert |
| wrCe | input | 1 | Write clock enable |
| wrEn | input | 1 | Write enable |
| wrData | input | DATA_W | Word to store |
| rdCe | input | 1 | Read clock enable |
| rdEn | input | 1 | Read enable |
| rdRewind | input | 1 | Return read pointer to its post-reset position (read clock) |
| fullLvl | input | ADDR_W | Fill level at which `full` asserts |
| afLvl | input | ADDR_W | Fill level at which `almostFull` asserts |
| aeLvl | input | ADDR_W | Fill level at or below which `almostEmpty` asserts |
| rdData | output | DATA_W | Last word read |
| full | output | 1 | Full flag (write clock) |
| almostFull | output | 1 | Almost-full flag (write clock) |
| empty | output | 1 | Empty flag (read clock) |
| almostEmpty | output | 1 | Almost-empty flag (read clock) |

## Verification
The bench builds the block with ADDR_W = 3 and DATA_W = 8, giving eight storage slots. It sets fullLvl = 6, afLvl = 4 and aeLvl = 2. A few writes are therefore enough to cross every threshold and to attempt a write while full. The same small depth lets the full contents be drained and then replayed after a rewind. The replay brings the restored level back across the full threshold on the write side. The read clock runs at a period unrelated to the write clock, so every flag has to pass through the synchronizers.

// File: rtl/arf_pkg.sv
package arf_pkg;
  typedef struct packed {
    logic doWrite;
    logic doRead;
  } arfStrobe_t;
endpackage

// File: rtl/arf_sync.sv
module arf_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/arf_ctrl.sv
module arf_ctrl
  import arf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrCe,
  input  logic              wrEn,
  input  logic              rdCe,
  input  logic              rdEn,
  input  logic              rdRewind,
  input  logic [ADDR_W-1:0] fullLvl,
  input  logic [ADDR_W-1:0] afLvl,
  input  logic [ADDR_W-1:0] aeLvl,
  output arfStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              full,
  output logic              almostFull,
  output logic              empty,
  output logic              almostEmpty
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PTR_W-1:0] grayToBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  logic [PTR_W-1:0] wrBin, wrBinNext, wrGray, wrGrayNext;
  logic [PTR_W-1:0] rdGraySync, rdBinSync, wrLevelNext;
  logic             wrGo;

  // read domain
  logic [PTR_W-1:0] rdBin, rdBinNext, rdGray, rdGrayNext;
  logic [PTR_W-1:0] wrGraySync, wrBinSync, rdLevelNext;
  logic             rdGo;

  arf_sync #(.WIDTH(PTR_W)) uRdToWr (
    .clk (wrClk), .rstN(rstN), .din(rdGray), .dout(rdGraySync)
  );
  arf_sync #(.WIDTH(PTR_W)) uWrToRd (
    .clk (rdClk), .rstN(rstN), .din(wrGray), .dout(wrGraySync)
  );

  always_comb begin
    wrGo        = wrCe && wrEn && !full;
    wrBinNext   = wrBin + PTR_W'(wrGo);
    wrGrayNext  = wrBinNext ^ (wrBinNext >> 1);
    rdBinSync   = grayToBin(rdGraySync);
    wrLevelNext = wrBinNext - rdBinSync;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin      <= '0;
      wrGray     <= '0;
      full       <= 1'b0;
      almostFull <= 1'b0;
    end else begin
      wrBin      <= wrBinNext;
      wrGray     <= wrGrayNext;
      full       <= wrLevelNext >= {1'b0, fullLvl};
      almostFull <= wrLevelNext >= {1'b0, afLvl};
    end
  end

  always_comb begin
    rdGo        = rdCe && rdEn && !empty && !rdRewind;
    rdBinNext   = rdRewind ? '0 : rdBin + PTR_W'(rdGo);
    rdGrayNext  = rdBinNext ^ (rdBinNext >> 1);
    wrBinSync   = grayToBin(wrGraySync);
    rdLevelNext = wrBinSync - rdBinNext;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin       <= '0;
      rdGray      <= '0;
      empty       <= 1'b1;
      almostEmpty <= 1'b1;
    end else begin
      rdBin       <= rdBinNext;
      rdGray      <= rdGrayNext;
      empty       <= rdLevelNext == '0;
      almostEmpty <= rdLevelNext <= {1'b0, aeLvl};
    end
  end

  assign strobe.doWrite = wrGo;
  assign strobe.doRead  = rdGo;
  assign wrAddr         = wrBin[ADDR_W-1:0];
  assign rdAddr         = rdBin[ADDR_W-1:0];

  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrBin - rdBinSync) <= PTR_W'(DEPTH - 1)); // R3
  AST_FULL_HAS_AF: assert property (@(posedge wrClk) disable iff (!rstN)
    full |-> almostFull); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (!rstN)
    (wrBinSync - rdBin) <= PTR_W'(DEPTH)); // R5
  AST_EMPTY_HAS_AE: assert property (@(posedge rdClk) disable iff (!rstN)
    empty |-> almostEmpty); // R6
  AST_WR_GRAY_STEP: assert property (@(posedge wrClk) disable iff (!rstN)
    1'b1 |=> $countones(wrGray ^ $past(wrGray)) <= 1); // R9
  AST_RD_GRAY_STEP: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdRewind |=> $countones(rdGray ^ $past(rdGray)) <= 1); // R9
endmodule

// File: rtl/arf_mem.sv
module arf_mem
  import arf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  arfStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.doWrite) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)              rdData <= '0;
    else if (strobe.doRead) rdData <= store[rdAddr];
  end

  AST_RD_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    !strobe.doRead |=> $stable(rdData)); // R5
endmodule

// File: rtl/async_replay_fifo.sv
module async_replay_fifo
  import arf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrCe,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdCe,
  input  logic              rdEn,
  input  logic              rdRewind,
  input  logic [ADDR_W-1:0] fullLvl,
  input  logic [ADDR_W-1:0] afLvl,
  input  logic [ADDR_W-1:0] aeLvl,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              almostFull,
  output logic              empty,
  output logic              almostEmpty
);
  arfStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  arf_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrCe(wrCe), .wrEn(wrEn), .rdCe(rdCe), .rdEn(rdEn), .rdRewind(rdRewind),
    .fullLvl(fullLvl), .afLvl(afLvl), .aeLvl(aeLvl),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .full(full), .almostFull(almostFull), .empty(empty), .almostEmpty(almostEmpty)
  );

  arf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uMem (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/async_replay_fifo_test.sv
module async_replay_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int FULL_LVL   = 6;
  localparam int AF_LVL     = 4;
  localparam int AE_LVL     = 2;

  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic wrCe = 0, wrEn = 0, rdCe = 0, rdEn = 0, rdRewind = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic full, almostFull, empty, almostEmpty;

  int checks = 0, errors = 0;
  int modelCount = 0;
  bit finished = 0;
  logic [DATA_W-1:0] expQ[$];
  logic [DATA_W-1:0] histQ[$];

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2)  rdClk = ~rdClk;

  async_replay_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrCe(wrCe), .wrEn(wrEn), .wrData(wrData),
    .rdCe(rdCe), .rdEn(rdEn), .rdRewind(rdRewind),
    .fullLvl(ADDR_W'(FULL_LVL)), .afLvl(ADDR_W'(AF_LVL)), .aeLvl(ADDR_W'(AE_LVL)),
    .rdData(rdData), .full(full), .almostFull(almostFull),
    .empty(empty), .almostEmpty(almostEmpty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: one write attempt; accepted words go to the scoreboard
  task automatic wrPush(input logic [DATA_W-1:0] d, input logic ce);
    bit accept;
    @(negedge wrClk);
    wrCe = ce; wrEn = 1; wrData = d;
    accept = ce && !full;
    @(negedge wrClk);
    wrEn = 0; wrCe = 1;
    if (accept) begin
      expQ.push_back(d);
      histQ.push_back(d);
      modelCount++;
    end
  endtask

  task automatic rdPop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rdClk); rdCe = 1; rdEn = 1;
      @(negedge rdClk); rdEn = 0;
    end
  endtask

  task automatic waitRd(input int n);
    for (int i = 0; i < n; i++) @(negedge rdClk);
  endtask

  task automatic waitWr(input int n);
    for (int i = 0; i < n; i++) @(negedge wrClk);
  endtask

  // monitor: compare each accepted read against the scoreboard (R2)
  always @(posedge rdClk) begin
    bit goPre;
    goPre = rstN && rdCe && rdEn && !empty && !rdRewind;
    #1;
    if (goPre) begin
      if (expQ.size() == 0) check(0, "R2 unexpected read", int'(rdData), -1);
      else begin
        logic [DATA_W-1:0] e;
        e = expQ.pop_front();
        check(rdData == e, "R2 read order", int'(rdData), int'(e));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitWr(3);
    check(empty == 1 && almostEmpty == 1, "R1 empty flags in reset", int'({empty, almostEmpty}), 3);
    check(full == 0 && almostFull == 0, "R1 full flags in reset", int'({full, almostFull}), 0);
    check(rdData == 0, "R1 rdData in reset", int'(rdData), 0);
    @(negedge wrClk); rstN = 1;
    waitWr(2);

    for (int i = 0; i < 3; i++) wrPush(DATA_W'(8'hA0 + i), 1);
    check(almostFull == 0, "R4 below afLvl", int'(almostFull), 0);
    wrPush(8'hEE, 0); // R7: wrCe low, must be ignored
    check(almostFull == 0, "R7 write without wrCe ignored", int'(almostFull), 0);
    wrPush(8'hA3, 1);
    check(almostFull == 1, "R4 level reaches afLvl", int'(almostFull), 1);
    check(full == 0, "R3 below fullLvl", int'(full), 0);
    wrPush(8'hA4, 1);
    check(full == 0, "R3 level 5", int'(full), 0);
    wrPush(8'hA5, 1);
    check(full == 1, "R3 full at fullLvl", int'(full), 1);
    wrPush(8'h77, 1); // R3: write while full is ignored
    check(full == 1 && modelCount == FULL_LVL, "R3 write while full", modelCount, FULL_LVL);

    waitRd(6);
    check(empty == 0 && almostEmpty == 0, "R6 level 6 seen on read side", int'({empty, almostEmpty}), 0);

    @(negedge rdClk); rdCe = 0; rdEn = 1;
    @(negedge rdClk); rdEn = 0; rdCe = 1;
    waitRd(1);
    check(rdData == 0, "R7 read without rdCe ignored", int'(rdData), 0);

    rdPop(4);
    check(almostEmpty == 1 && empty == 0, "R6 level 2 almost empty", int'({empty, almostEmpty}), 1);
    rdPop(2);
    check(empty == 1 && almostEmpty == 1, "R5 drained", int'({empty, almostEmpty}), 3);
    check(expQ.size() == 0, "R2 all words returned", expQ.size(), 0);
    rdPop(1); // read while empty
    check(rdData == 8'hA5, "R5 read while empty holds rdData", int'(rdData), 8'hA5);
    waitWr(6);
    check(full == 0 && almostFull == 0, "R3 full clears after reads", int'({full, almostFull}), 0);

    @(negedge rdClk); rdRewind = 1;
    @(negedge rdClk); rdRewind = 0;
    check(rdData == 8'hA5, "R8 rewind leaves rdData", int'(rdData), 8'hA5);
    foreach (histQ[i]) expQ.push_back(histQ[i]);
    waitRd(1);
    check(empty == 0 && almostEmpty == 0, "R8 level restored on read side", int'({empty, almostEmpty}), 0);
    waitWr(6);
    check(full == 1, "R8 level restored on write side", int'(full), 1);
    rdPop(6);
    check(expQ.size() == 0, "R8 replay complete", expQ.size(), 0);
    check(empty == 1, "R8 empty after replay", int'(empty), 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule